// File: doc/BRIEF.md
# Enable-Edge Latched 4K x 1 Static RAM

A behavioural, synthesizable model of a 4096 x 1 static memory whose address is taken on the falling edge of an active-low chip enable, not on a free-running clock strobe. The enable pins are sampled on `clk_i`. A falling enable opens an access cycle, and a rising enable closes it. The twelve address bits are split into a 6-bit row and a 6-bit column, and both are held in registers for the whole cycle. Bits 0, 1, 2, 6, 7 and 8 form the row. Bits 3, 4, 5, 9, 10 and 11 form the column.

Data in passes through a latch that follows `din_i` while write enable is low and holds its value once write enable goes high. A write cycle stores that held bit into the addressed cell when the cycle closes. In a read cycle, the cell decode is gated one clock after address capture. The bit is then loaded into an output latch, and a separate output-enable flag models the three-state driver. The output latch keeps its value after the cycle ends. The array has no refresh and no reset, so its contents stay until they are overwritten.

Top module: `edge_sram4k`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first read, `dout_oe_o` is 0 and `dout_o` is 0.
- R2: The address is captured at the first rising `clk_i` edge that samples `ce_ni` low after it was sampled high. Changes to `addr_i` later in the same cycle do not affect which cell is read or written.
- R3: If `we_ni` is sampled low at any edge of a cycle, the cycle is a write. The bit held by the data-in latch is stored into the captured cell at the edge that samples `ce_ni` high again. A later write to the same cell replaces the earlier bit.
- R4: In a read cycle (`we_ni` high), `dout_o` carries the captured cell and `dout_oe_o` is 1 from the second rising edge after the cycle opens.
- R5: `dout_oe_o` is 0 whenever `ce_ni` is high.
- R6: `dout_oe_o` is 0 whenever `we_ni` is low.
- R7: `dout_o` keeps the last bit read after the cycle closes and while the chip is idle.
- R8: All 4096 addresses select distinct cells. A full pattern written to every address reads back unchanged.
- R9: Stored contents survive an assertion of `rst_ni` and any idle time.
- R10: The data-in latch follows `din_i` only at edges where `we_ni` is low. Changes to `din_i` while `we_ni` is high do not change the stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset of control state (not the array) |
| ce_ni | input | 1 | Active-low chip enable; its fall opens a cycle |
| we_ni | input | 1 | Active-low write enable |
| addr_i | input | 12 | Word address |
| din_i | input | 1 | Write data |
| dout_o | output | 1 | Output latch |
| dout_oe_o | output | 1 | Output-driver enable (1 = driving, 0 = high impedance) |

## Verification
A row or column register that tracks the live address instead of holding its captured value shows up at the read one edge later. To expose this, the bench inverts `addr_i` after capture in every cycle. A wrong split or a collapsed decode corrupts readback during the full 4096-location sweep, at the first cell pair that aliases. A data-in latch that stays open, or a commit at the wrong edge, shows up at the next read of that cell. Errors in output-enable gating appear in the same half-cycle as the `ce_ni` or `we_ni` change.

// File: rtl/edge_sram4k_pkg.sv
package edge_sram4k_pkg;
  localparam int unsigned GRP_W  = 3;
  localparam int unsigned ADDR_W = 4 * GRP_W;
  localparam int unsigned ROW_W  = 2 * GRP_W;
  localparam int unsigned COL_W  = 2 * GRP_W;

  typedef struct packed {
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
  } cell_addr_t;
endpackage

// File: rtl/edge_sram4k_addr_reg.sv
module edge_sram4k_addr_reg #(
  parameter int unsigned GRP_W  = 3,
  localparam int unsigned ADDR_W = 4 * GRP_W,
  localparam int unsigned ROW_W  = 2 * GRP_W,
  localparam int unsigned COL_W  = 2 * GRP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o
);
  logic [ROW_W-1:0] row_d;
  logic [COL_W-1:0] col_d;

  // row: groups 0 and 2, column: groups 1 and 3
  always_comb begin
    row_d = {addr_i[3*GRP_W-1:2*GRP_W], addr_i[GRP_W-1:0]};
    col_d = {addr_i[4*GRP_W-1:3*GRP_W], addr_i[2*GRP_W-1:GRP_W]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o <= '0;
      col_o <= '0;
    end else if (cap_i) begin
      row_o <= row_d;
      col_o <= col_d;
    end
  end
endmodule

// File: rtl/edge_sram4k_ctrl.sv
module edge_sram4k_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic din_i,
  output logic ce_q_o,
  output logic cap_o,
  output logic gate_o,
  output logic fin_o,
  output logic commit_o,
  output logic din_q_o
);
  logic ce_q, active_q, gate_q, wr_pend_q, din_q;
  logic cap, fin;

  assign cap = ce_q & ~ce_ni;
  assign fin = active_q & ~ce_q & ce_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q      <= 1'b1;
      active_q  <= 1'b0;
      gate_q    <= 1'b0;
      wr_pend_q <= 1'b0;
    end else begin
      ce_q   <= ce_ni;
      gate_q <= cap;
      if (cap)      active_q <= 1'b1;
      else if (fin) active_q <= 1'b0;
      if (fin)                              wr_pend_q <= 1'b0;
      else if ((active_q | cap) && !we_ni)  wr_pend_q <= 1'b1;
    end
  end

  // data-in latch: open while write enable is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     din_q <= 1'b0;
    else if (!we_ni) din_q <= din_i;
  end

  assign ce_q_o   = ce_q;
  assign cap_o    = cap;
  assign gate_o   = gate_q;
  assign fin_o    = fin;
  assign commit_o = fin & wr_pend_q;
  assign din_q_o  = din_q;
endmodule

// File: rtl/edge_sram4k_array.sv
module edge_sram4k_array #(
  parameter int unsigned ROW_W = 6,
  parameter int unsigned COL_W = 6,
  localparam int unsigned N_ROW = 1 << ROW_W,
  localparam int unsigned N_COL = 1 << COL_W
) (
  input  logic             clk_i,
  input  logic             wr_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             wbit_i,
  output logic             rbit_o
);
  logic [N_COL-1:0] cell_q [N_ROW];

  // no reset: contents are static
  always_ff @(posedge clk_i) begin
    if (wr_i) cell_q[row_i][col_i] <= wbit_i;
  end

  assign rbit_o = cell_q[row_i][col_i];
endmodule

// File: rtl/edge_sram4k.sv
module edge_sram4k
  import edge_sram4k_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              dout_oe_o
);
  cell_addr_t sel_q;
  logic ce_q, cap, gate, fin, commit, din_q, rbit;
  logic dout_q, rd_valid_q;

  edge_sram4k_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .we_ni    (we_ni),
    .din_i    (din_i),
    .ce_q_o   (ce_q),
    .cap_o    (cap),
    .gate_o   (gate),
    .fin_o    (fin),
    .commit_o (commit),
    .din_q_o  (din_q)
  );

  edge_sram4k_addr_reg #(.GRP_W(GRP_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .addr_i (addr_i),
    .row_o  (sel_q.row),
    .col_o  (sel_q.col)
  );

  edge_sram4k_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_array (
    .clk_i  (clk_i),
    .wr_i   (commit),
    .row_i  (sel_q.row),
    .col_i  (sel_q.col),
    .wbit_i (din_q),
    .rbit_o (rbit)
  );

  // output latch loads once the decode is gated in a read cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q     <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      if (gate && we_ni) dout_q <= rbit;
      if (fin)                rd_valid_q <= 1'b0;
      else if (gate && we_ni) rd_valid_q <= 1'b1;
    end
  end

  assign dout_o    = dout_q;
  assign dout_oe_o = rd_valid_q & ~ce_ni & we_ni;
endmodule

// File: rtl/edge_sram4k_chk.sv
module edge_sram4k_chk #(
  parameter int unsigned ROW_W = 6,
  parameter int unsigned COL_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_ni,
  input logic             we_ni,
  input logic             ce_q,
  input logic             dout_o,
  input logic             dout_oe_o,
  input logic [ROW_W-1:0] row_q,
  input logic [COL_W-1:0] col_q
);
  a_r5_oe_off_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !dout_oe_o);

  a_r6_oe_off_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |-> !dout_oe_o);

  a_r7_dout_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> $stable(dout_o));

  a_r2_row_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !ce_q) |=> $stable(row_q));

  a_r2_col_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !ce_q) |=> $stable(col_q));

  a_r4_oe_after_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dout_oe_o) |-> $past(!ce_ni));
endmodule

bind edge_sram4k edge_sram4k_chk #(
  .ROW_W(edge_sram4k_pkg::ROW_W),
  .COL_W(edge_sram4k_pkg::COL_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_ni     (ce_ni),
  .we_ni     (we_ni),
  .ce_q      (ce_q),
  .dout_o    (dout_o),
  .dout_oe_o (dout_oe_o),
  .row_q     (sel_q.row),
  .col_q     (sel_q.col)
);

// File: tb/edge_sram4k_tb_top.sv
module edge_sram4k_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [11:0] addr = '0;
  logic dout, dout_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  edge_sram4k dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n),
    .addr_i(addr), .din_i(din), .dout_o(dout), .dout_oe_o(dout_oe)
  );

  // {data, addr}
  localparam logic [12:0] VEC_TBL [8] = '{
    {1'b1, 12'h000}, {1'b0, 12'hFFF}, {1'b1, 12'h041}, {1'b1, 12'hFBE},
    {1'b0, 12'h555}, {1'b1, 12'hAAA}, {1'b1, 12'h800}, {1'b0, 12'h001}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic pat(input logic [11:0] a);
    logic [31:0] h = {20'd0, a} * 32'h9E37_79B1;
    return h[17] ^ h[29] ^ a[0];
  endfunction

  task automatic wr(input logic [11:0] a, input logic d);
    ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    chk("R6 oe during write", dout_oe, 1'b0);
    addr = ~a;                          // R2: live address moves
    @(negedge clk);
    we_n = 1'b1; din = ~d;              // R10: latch closed
    @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a, input logic exp, input string req);
    ce_n = 1'b0; we_n = 1'b1; addr = a;
    @(negedge clk);
    addr = ~a;                          // R2
    @(negedge clk);
    chk({req, " R4 oe"}, dout_oe, 1'b1);
    chk({req, " R4 data"}, dout, exp);
    ce_n = 1'b1;
    #1 chk("R5 oe with ce high", dout_oe, 1'b0);
    @(negedge clk);
    chk("R7 dout held", dout, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", dout_oe, 1'b0);
    chk("R1 dout in reset", dout, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe after reset", dout_oe, 1'b0);
    chk("R1 dout after reset", dout, 1'b0);

    foreach (VEC_TBL[i]) wr(VEC_TBL[i][11:0], VEC_TBL[i][12]);
    foreach (VEC_TBL[i]) rd(VEC_TBL[i][11:0], VEC_TBL[i][12], "R2 R10 table");

    // R3: overwrite, last write wins
    wr(12'h123, 1'b1);
    wr(12'h123, 1'b0);
    rd(12'h123, 1'b0, "R3 overwrite");
    wr(12'h123, 1'b1);
    rd(12'h123, 1'b1, "R3 overwrite back");

    // R6: write enable dropped during a read cycle
    ce_n = 1'b0; we_n = 1'b1; addr = 12'h041;
    @(negedge clk); @(negedge clk);
    chk("R4 oe before we drop", dout_oe, 1'b1);
    we_n = 1'b0; din = 1'b1;
    #1 chk("R6 oe with we low", dout_oe, 1'b0);
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
    rd(12'h041, 1'b1, "R3 write after read");

    // R9: reset and idle keep contents
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    rd(12'hFBE, 1'b1, "R9 after reset");
    rd(12'h555, 1'b0, "R9 after reset");

    // R8: full sweep
    for (int a = 0; a < 4096; a++) wr(12'(a), pat(12'(a)));
    for (int a = 0; a < 4096; a++) rd(12'(a), pat(12'(a)), "R8 sweep");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule